// File: doc/BRIEF.md
# Opcode Field Decoder for an Eight-Bit Accumulator Processor

This block takes one opcode byte and turns it into the control fields an execution unit needs. It has no clock and no state. The byte is split into three fields: a two-bit quadrant in bits [7:6], a three-bit destination field in bits [5:3] and a three-bit source field in bits [2:0]. Two quadrants are decoded uniformly:

- register-to-register moves;
- accumulator arithmetic and logic.

The other two quadrants are decoded column by column:

- pointer, immediate, increment and flag operations;
- branches, stack operations, I/O and control.

The outputs are:

- an instruction class;
- destination and source register indices;
- an ALU operation code and a branch condition;
- a register-pair index with a flag that marks the status-word pair;
- the instruction length in bytes;
- a halt indication;
- a memory-operand flag;
- a valid flag for unassigned opcodes.

An execution unit drives the fetched opcode onto `op_i` and reads the outputs in the same cycle. Operand bytes, fetch sequencing and execution belong to other blocks. Register indices 0 to 7 stand for B, C, D, E, H, L, the memory byte addressed by HL, and A.

Top module: `opdec_top`

## Requirements
- R1: `valid_o` is 0 for exactly twelve opcodes and 1 for all others. The twelve are 0x08, 0x10, 0x18, 0x20, 0x28, 0x30, 0x38, 0xCB, 0xD9, 0xDD, 0xED and 0xFD.
- R2: `class_o` uses these codes. 0 no-op (0x00 and every invalid opcode). 1 register move. 2 halt. 3 ALU with a register operand. 4 ALU with an immediate operand. 5 accumulator/flag group. 6 move immediate. 7 8-bit increment/decrement. 8 pair operation (load-pair-immediate, pair add, pair increment, pair decrement). 9 memory transfer (indirect or direct load/store). 10 branch (jump, call, return, restart, jump through HL). 11 stack (push, pop, exchange with stack top, load SP from HL). 12 I/O (in, out). 13 control (exchange DE/HL, interrupt disable, interrupt enable).
- R3: In quadrant 1, `dst_o` is bits [5:3] and `src_o` is bits [2:0]. Opcode 0x76 is the exception: it gives class 2 with `halt_o` = 1. `halt_o` is 1 for no other opcode.
- R4: In quadrant 2, `alu_op_o` is bits [5:3] and `src_o` is bits [2:0]. The operation codes are 0 add, 1 add with carry, 2 subtract, 3 subtract with borrow, 4 and, 5 exclusive or, 6 or, 7 compare.
- R5: Conditional returns (column 0), jumps (column 2) and calls (column 4) in quadrant 3 set `cond_use_o` = 1 and `cond_o` = bits [5:3]. The condition codes are 0 not zero, 1 zero, 2 no carry, 3 carry, 4 parity odd, 5 parity even, 6 plus, 7 minus. `cond_use_o` is 0 for every other opcode.
- R6: For valid opcodes in quadrants 0 and 3, `pair_o` is bits [5:4] (0 BC, 1 DE, 2 HL, 3 SP or status word). `pair_psw_o` is 1 only for 0xF1 and 0xF5. In quadrants 1 and 2 `pair_o` is 0.
- R7: `len_o` is 2 for move-immediate, ALU-immediate, in and out. It is 3 for load-pair-immediate, the four direct transfers (0x22, 0x2A, 0x32, 0x3A), jumps and calls, conditional or not. It is 1 for everything else.
- R8: `mem_o` is 1 when a register field that the opcode uses equals 6 in quadrants 0, 1 or 2. That covers increment, decrement and move-immediate destinations, move destination or source, and ALU source. It is 0 for halt and for all of quadrant 3.
- R9: Quadrant 0 column 7 gives class 5 with `alu_op_o` = bits [5:3]. Quadrant 3 column 6 gives class 4 with `alu_op_o` = bits [5:3].
- R10: Any field that an opcode does not use reads as 0. An invalid opcode gives class 0, length 1, and 0 on every other output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 8 | Opcode byte |
| valid_o | output | 1 | Opcode is assigned |
| class_o | output | 4 | Instruction class code |
| dst_o | output | 3 | Destination register index |
| src_o | output | 3 | Source register index |
| alu_op_o | output | 3 | ALU or accumulator-group operation |
| cond_o | output | 3 | Branch condition code |
| cond_use_o | output | 1 | Opcode is conditional |
| pair_o | output | 2 | Register-pair index |
| pair_psw_o | output | 1 | Pair 3 means the status word |
| len_o | output | 2 | Instruction length in bytes |
| halt_o | output | 1 | Halt opcode |
| mem_o | output | 1 | A register field selects memory at HL |

## Verification
The cases hardest to reach are the isolated slots where the uniform rules break down:

- 0x76, which sits inside the move grid but must not raise the memory flag;
- the scattered unassigned slots in the two irregular quadrants;
- the status-word pair, which appears only in the push/pop columns of the top quadrant.

The stimulus drives all 256 opcodes, one per cycle, against a behavioural model built from hex lists. It then repeats targeted opcodes at these slots so that each rule is checked on its own.

// File: rtl/opdec_pkg.sv
package opdec_pkg;
  localparam int OPC_W  = 8;
  localparam int FLD_W  = 3;
  localparam int PAIR_W = 2;
  localparam int LEN_W  = 2;
  localparam logic [FLD_W-1:0] MEM_IDX = 3'd6;

  typedef enum logic [3:0] {
    C_NOP = 4'd0, C_MOVE = 4'd1, C_HALT = 4'd2, C_ALU_REG = 4'd3,
    C_ALU_IMM = 4'd4, C_ACC = 4'd5, C_MOVE_IMM = 4'd6, C_INCDEC = 4'd7,
    C_PAIR = 4'd8, C_MEMX = 4'd9, C_BRANCH = 4'd10, C_STACK = 4'd11,
    C_IO = 4'd12, C_CTRL = 4'd13
  } cls_e;

  typedef struct packed {
    logic              valid;
    cls_e              cls;
    logic [FLD_W-1:0]  dst;
    logic [FLD_W-1:0]  src;
    logic [FLD_W-1:0]  alu;
    logic [FLD_W-1:0]  cond;
    logic              cond_use;
    logic [PAIR_W-1:0] pair;
    logic              psw;
    logic [LEN_W-1:0]  len;
    logic              halt;
    logic              mem;
  } dec_t;

  function automatic logic [1:0] f_quad(input logic [OPC_W-1:0] op);
    return op[7:6];
  endfunction

  function automatic logic [FLD_W-1:0] f_dst(input logic [OPC_W-1:0] op);
    return op[5:3];
  endfunction

  function automatic logic [FLD_W-1:0] f_src(input logic [OPC_W-1:0] op);
    return op[2:0];
  endfunction

  // Result with every field at its quiet value; length one byte.
  function automatic dec_t f_blank(input logic is_valid);
    dec_t r;
    r          = '0;
    r.valid    = is_valid;
    r.cls      = C_NOP;
    r.len      = 2'd1;
    return r;
  endfunction

  function automatic logic f_is_mem(input logic [FLD_W-1:0] idx);
    return idx == MEM_IDX;
  endfunction
endpackage

// File: rtl/opdec_lo.sv
module opdec_lo
  import opdec_pkg::*;
(
  input  logic [FLD_W-1:0] dst_i,
  input  logic [FLD_W-1:0] src_i,
  output dec_t             res_o
);
  dec_t r;
  always_comb begin
    r      = f_blank(1'b1);
    r.pair = dst_i[2:1];
    unique case (src_i)
      3'd0: begin
        r.valid = (dst_i == 3'd0);
        if (dst_i != 3'd0) r.pair = '0;
      end
      3'd1: begin
        r.cls = C_PAIR;
        r.len = dst_i[0] ? 2'd1 : 2'd3;
      end
      3'd2: begin
        r.cls = C_MEMX;
        r.len = dst_i[2] ? 2'd3 : 2'd1;
      end
      3'd3: r.cls = C_PAIR;
      3'd4, 3'd5: begin
        r.cls = C_INCDEC;
        r.dst = dst_i;
        r.mem = f_is_mem(dst_i);
      end
      3'd6: begin
        r.cls = C_MOVE_IMM;
        r.dst = dst_i;
        r.mem = f_is_mem(dst_i);
        r.len = 2'd2;
      end
      default: begin
        r.cls = C_ACC;
        r.alu = dst_i;
      end
    endcase
    res_o = r;
    AST_LO_MEM_CLASS: assert (!r.mem || r.cls == C_INCDEC || r.cls == C_MOVE_IMM)
      else $error("memory flag on class %0d", r.cls); // R8
    AST_LO_NO_COND: assert (!r.cond_use && !r.psw)
      else $error("quadrant 0 set condition or status pair"); // R5
  end
endmodule

// File: rtl/opdec_mid.sv
module opdec_mid
  import opdec_pkg::*;
(
  input  logic             alu_i,
  input  logic [FLD_W-1:0] dst_i,
  input  logic [FLD_W-1:0] src_i,
  output dec_t             res_o
);
  dec_t r;
  logic halt_slot;
  always_comb begin
    r         = f_blank(1'b1);
    halt_slot = !alu_i && f_is_mem(dst_i) && f_is_mem(src_i);
    if (alu_i) begin
      r.cls = C_ALU_REG;
      r.alu = dst_i;
      r.src = src_i;
      r.mem = f_is_mem(src_i);
    end else if (halt_slot) begin
      r.cls  = C_HALT;
      r.halt = 1'b1;
    end else begin
      r.cls = C_MOVE;
      r.dst = dst_i;
      r.src = src_i;
      r.mem = f_is_mem(dst_i) || f_is_mem(src_i);
    end
    res_o = r;
    AST_HALT_QUIET: assert (!r.halt || (!r.mem && r.dst == '0 && r.src == '0))
      else $error("halt carries operands"); // R3
    AST_MID_ONE_BYTE: assert (r.len == 2'd1)
      else $error("register form longer than one byte"); // R7
  end
endmodule

// File: rtl/opdec_hi.sv
module opdec_hi
  import opdec_pkg::*;
(
  input  logic [FLD_W-1:0] dst_i,
  input  logic [FLD_W-1:0] src_i,
  output dec_t             res_o
);
  dec_t r;
  always_comb begin
    r      = f_blank(1'b1);
    r.pair = dst_i[2:1];
    unique case (src_i)
      3'd0: begin
        r.cls = C_BRANCH; r.cond = dst_i; r.cond_use = 1'b1;
      end
      3'd1: begin
        if (!dst_i[0]) begin
          r.cls = C_STACK; r.psw = (dst_i == 3'd6);
        end else if (dst_i == 3'd1 || dst_i == 3'd5) begin
          r.cls = C_BRANCH;
        end else if (dst_i == 3'd7) begin
          r.cls = C_STACK;
        end else begin
          r.valid = 1'b0;
        end
      end
      3'd2: begin
        r.cls = C_BRANCH; r.cond = dst_i; r.cond_use = 1'b1; r.len = 2'd3;
      end
      3'd3: begin
        unique case (dst_i)
          3'd0:       begin r.cls = C_BRANCH; r.len = 2'd3; end
          3'd1:       r.valid = 1'b0;
          3'd2, 3'd3: begin r.cls = C_IO; r.len = 2'd2; end
          3'd4:       r.cls = C_STACK;
          default:    r.cls = C_CTRL;
        endcase
      end
      3'd4: begin
        r.cls = C_BRANCH; r.cond = dst_i; r.cond_use = 1'b1; r.len = 2'd3;
      end
      3'd5: begin
        if (!dst_i[0]) begin
          r.cls = C_STACK; r.psw = (dst_i == 3'd6);
        end else if (dst_i == 3'd1) begin
          r.cls = C_BRANCH; r.len = 2'd3;
        end else begin
          r.valid = 1'b0;
        end
      end
      3'd6: begin
        r.cls = C_ALU_IMM; r.alu = dst_i; r.len = 2'd2;
      end
      default: r.cls = C_BRANCH;
    endcase
    if (!r.valid) r.pair = '0;
    res_o = r;
    AST_HI_COND_BRANCH: assert (!r.cond_use || r.cls == C_BRANCH)
      else $error("condition on non-branch class %0d", r.cls); // R5
    AST_HI_INVALID_QUIET: assert (r.valid || (r.cls == C_NOP && r.len == 2'd1 && r.pair == '0))
      else $error("invalid opcode with live fields"); // R10
    AST_HI_PSW_STACK: assert (!r.psw || (r.cls == C_STACK && r.pair == 2'd3))
      else $error("status pair outside push/pop"); // R6
    AST_HI_NO_MEM: assert (!r.mem)
      else $error("memory flag in quadrant 3"); // R8
  end
endmodule

// File: rtl/opdec_top.sv
module opdec_top
  import opdec_pkg::*;
(
  input  logic [7:0] op_i,
  output logic       valid_o,
  output logic [3:0] class_o,
  output logic [2:0] dst_o,
  output logic [2:0] src_o,
  output logic [2:0] alu_op_o,
  output logic [2:0] cond_o,
  output logic       cond_use_o,
  output logic [1:0] pair_o,
  output logic       pair_psw_o,
  output logic [1:0] len_o,
  output logic       halt_o,
  output logic       mem_o
);
  logic [1:0]       quad;
  logic [FLD_W-1:0] dfld, sfld;
  dec_t             lo_res, mid_res, hi_res, sel;

  assign quad = f_quad(op_i);
  assign dfld = f_dst(op_i);
  assign sfld = f_src(op_i);

  opdec_lo  u_lo  (.dst_i(dfld), .src_i(sfld), .res_o(lo_res));
  opdec_mid u_mid (.alu_i(quad[1]), .dst_i(dfld), .src_i(sfld), .res_o(mid_res));
  opdec_hi  u_hi  (.dst_i(dfld), .src_i(sfld), .res_o(hi_res));

  always_comb begin
    unique case (quad)
      2'd0:    sel = lo_res;
      2'd3:    sel = hi_res;
      default: sel = mid_res;
    endcase
  end

  assign valid_o    = sel.valid;
  assign class_o    = sel.cls;
  assign dst_o      = sel.dst;
  assign src_o      = sel.src;
  assign alu_op_o   = sel.alu;
  assign cond_o     = sel.cond;
  assign cond_use_o = sel.cond_use;
  assign pair_o     = sel.pair;
  assign pair_psw_o = sel.psw;
  assign len_o      = sel.len;
  assign halt_o     = sel.halt;
  assign mem_o      = sel.mem;
endmodule

// File: tb/opdec_top_bench.sv
module opdec_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] op;
  logic       valid_o, cond_use_o, pair_psw_o, halt_o, mem_o;
  logic [3:0] class_o;
  logic [2:0] dst_o, src_o, alu_op_o, cond_o;
  logic [1:0] pair_o, len_o;

  opdec_top u_opdec_top (
    .op_i(op), .valid_o(valid_o), .class_o(class_o), .dst_o(dst_o),
    .src_o(src_o), .alu_op_o(alu_op_o), .cond_o(cond_o),
    .cond_use_o(cond_use_o), .pair_o(pair_o), .pair_psw_o(pair_psw_o),
    .len_o(len_o), .halt_o(halt_o), .mem_o(mem_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  // expected values, one per output
  int e_val, e_cls, e_dst, e_src, e_alu, e_cond, e_cu, e_pair, e_psw, e_len, e_halt, e_mem;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s op=%02h actual=%0d expected=%0d", tag, op, act, exp);
    end
  endtask

  function automatic bit in_list(input int v, input int lst[$]);
    foreach (lst[i]) if (lst[i] == v) return 1'b1;
    return 1'b0;
  endfunction

  // Behavioural model: hex lists and arithmetic on integers.
  task automatic model(input int o);
    int qq, hi3, lo3;
    int bad[$]   = '{'h08,'h10,'h18,'h20,'h28,'h30,'h38,'hCB,'hD9,'hDD,'hED,'hFD};
    int three[$] = '{'h01,'h11,'h21,'h31,'h22,'h2A,'h32,'h3A,'hC3,'hCD};
    int two[$]   = '{'hD3,'hDB};
    int ctl[$]   = '{'hEB,'hF3,'hFB};
    int stk[$]   = '{'hC1,'hD1,'hE1,'hF1,'hC5,'hD5,'hE5,'hF5,'hE3,'hF9};
    int br[$]    = '{'hC9,'hE9,'hC3,'hCD};
    int mx[$]    = '{'h02,'h12,'h0A,'h1A,'h22,'h2A,'h32,'h3A};
    qq = o / 64; hi3 = (o / 8) % 8; lo3 = o % 8;
    e_val = 1; e_cls = 0; e_dst = 0; e_src = 0; e_alu = 0; e_cond = 0;
    e_cu = 0; e_pair = 0; e_psw = 0; e_len = 1; e_halt = 0; e_mem = 0;
    if (in_list(o, bad)) begin e_val = 0; return; end
    if (qq == 0 || qq == 3) e_pair = hi3 / 2;
    if (in_list(o, three)) e_len = 3;
    if (in_list(o, two)) e_len = 2;
    if (o == 'hF1 || o == 'hF5) e_psw = 1;
    if (o == 'h76) begin e_cls = 2; e_halt = 1; end
    else if (qq == 1) begin
      e_cls = 1; e_dst = hi3; e_src = lo3; e_mem = (hi3 == 6 || lo3 == 6);
    end else if (qq == 2) begin
      e_cls = 3; e_alu = hi3; e_src = lo3; e_mem = (lo3 == 6);
    end else if (qq == 0) begin
      if (lo3 == 1 || lo3 == 3) e_cls = 8;
      if (in_list(o, mx)) e_cls = 9;
      if (lo3 == 4 || lo3 == 5) begin e_cls = 7; e_dst = hi3; e_mem = (hi3 == 6); end
      if (lo3 == 6) begin e_cls = 6; e_dst = hi3; e_mem = (hi3 == 6); e_len = 2; end
      if (lo3 == 7) begin e_cls = 5; e_alu = hi3; end
    end else begin
      if (lo3 == 0 || lo3 == 2 || lo3 == 4) begin
        e_cls = 10; e_cu = 1; e_cond = hi3;
        if (lo3 != 0) e_len = 3;
      end
      if (lo3 == 7 || in_list(o, br)) e_cls = 10;
      if (in_list(o, stk)) e_cls = 11;
      if (in_list(o, two)) e_cls = 12;
      if (in_list(o, ctl)) e_cls = 13;
      if (lo3 == 6) begin e_cls = 4; e_alu = hi3; e_len = 2; end
    end
  endtask

  task automatic compare_all(input string tag);
    model(int'(op));
    chk({tag, " valid R1"},    valid_o,    e_val);
    chk({tag, " class R2"},    class_o,    e_cls);
    chk({tag, " dst R3"},      dst_o,      e_dst);
    chk({tag, " src R4"},      src_o,      e_src);
    chk({tag, " alu R9"},      alu_op_o,   e_alu);
    chk({tag, " cond R5"},     cond_o,     e_cond);
    chk({tag, " cond_use R5"}, cond_use_o, e_cu);
    chk({tag, " pair R6"},     pair_o,     e_pair);
    chk({tag, " psw R6"},      pair_psw_o, e_psw);
    chk({tag, " len R7"},      len_o,      e_len);
    chk({tag, " halt R3"},     halt_o,     e_halt);
    chk({tag, " mem R8"},      mem_o,      e_mem);
  endtask

  task automatic drive(input logic [7:0] v);
    @(posedge clk); #1; op = v;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    op = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset state: no-op byte decodes to a valid one-byte no-op (R2, R10)
    chk("reset class R2", class_o, 0);
    chk("reset valid R1", valid_o, 1);
    chk("reset len R10", len_o, 1);
    rst_n = 1'b1;

    // full sweep against the model, one opcode per cycle
    for (int k = 0; k < 256; k++) begin
      drive(8'(k));
      compare_all("sweep");
    end

    // directed corners
    drive(8'h76); chk("halt R3", halt_o, 1); chk("halt no mem R8", mem_o, 0);
    drive(8'h77); chk("move to mem R8", mem_o, 1); chk("move src R3", src_o, 7);
    drive(8'h6E); chk("move from mem R8", mem_o, 1); chk("move dst R3", dst_o, 5);
    drive(8'hBE); chk("cmp mem alu R4", alu_op_o, 7); chk("cmp mem R8", mem_o, 1);
    drive(8'hFA); chk("jump minus cond R5", cond_o, 7); chk("jump len R7", len_o, 3);
    drive(8'hE0); chk("ret parity odd R5", cond_o, 4); chk("ret len R7", len_o, 1);
    drive(8'hF5); chk("push status R6", pair_psw_o, 1); chk("push pair R6", pair_o, 3);
    drive(8'h31); chk("load SP pair R6", pair_o, 3); chk("load SP not status R6", pair_psw_o, 0);
    drive(8'h27); chk("decimal adjust group R9", class_o, 5); chk("decimal adjust op R9", alu_op_o, 4);
    drive(8'hEE); chk("xor immediate R9", alu_op_o, 5); chk("xor immediate len R7", len_o, 2);
    drive(8'hDB); chk("in length R7", len_o, 2); chk("in class R2", class_o, 12);
    drive(8'h38); chk("gap q0 valid R1", valid_o, 0); chk("gap q0 pair R10", pair_o, 0);
    drive(8'hFD); chk("gap q3 valid R1", valid_o, 0); chk("gap q3 class R10", class_o, 0);
    drive(8'h35); chk("dec mem R8", mem_o, 1); chk("dec mem src R10", src_o, 0);
    drive(8'h3A); chk("direct load len R7", len_o, 3); chk("direct load class R2", class_o, 9);
    drive(8'hC9); chk("return no cond R5", cond_use_o, 0); chk("return alu R10", alu_op_o, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule